// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timer/counter channels, each built from a low byte and a high byte. A shared mode register sets each channel's options, and a shared control register holds the run bits and overflow flags. A channel counts one of two sources. In timer mode it counts a tick that a free-running prescaler raises once every `PRESCALE` clocks. In counter mode it counts falling edges on its count pin, after the pin passes through a synchronizer. An optional gate lets an external interrupt pin hold a channel off while its run bit is set.

Each channel runs in one of four modes: 13-bit, 16-bit, 8-bit auto-reload, or split. In split mode channel 0 becomes two 8-bit counters. Its high byte takes over channel 1's run bit and overflow flag. Channel 1 then runs free and feeds only the baud tick output, and channel 1 itself placed in mode 3 holds its count. The overflow flags act as interrupt requests. Each flag clears on an acknowledge input. A small register port gives read and write access to the control, mode and count registers.

Top module: `tmr_pair_top`

## Requirements
- R1: After reset every register reads 0x00 and both flags are low. An unmapped address reads 0x00.
- R2: Register addresses: 0 is control, 1 is mode, 2 and 3 are channel 0 low and high, 4 and 5 are channel 1 low and high. Control bits: 7 is flag 1, 6 is run 1, 5 is flag 0, 4 is run 0, and 3..0 are plain storage. The mode register has channel 1 in bits 7..4 and channel 0 in bits 3..0. Each nibble holds {gate, ext_src, m1, m0}. Register writes read back unchanged, and `ovf_flag_o` = {ctrl[7], ctrl[5]}.
- R3: With ext_src=1 a channel steps once for each falling edge on its count pin, and the step lands 3 clocks after the pin falls. With ext_src=0 it steps exactly once in every 6 clocks (`PRESCALE`).
- R4: With gate=1 a channel steps only while its run bit is set and its gate pin is high.
- R5: In mode 1 the two bytes form a 16-bit counter. The step from 0xFFFF wraps to 0x0000 and sets the channel's flag.
- R6: In mode 0 bits 4..0 of the low byte carry into the 8-bit high byte, giving 13 bits. Low bits 7..5 keep their value, and the wrap of all 13 bits sets the flag.
- R7: In mode 2 the low byte counts. From 0xFF it reloads from the high byte and sets the flag, and the high byte keeps its value.
- R8: With channel 0 in mode 3, its low byte is an 8-bit counter under run 0, gate 0 and ext_src 0. Its wrap sets flag 0.
- R9: With channel 0 in mode 3, its high byte steps on each prescaler tick while run 1 is set. Its wrap sets flag 1.
- R10: While channel 0 is in mode 3, channel 1 steps on its source regardless of run 1 and gate 1, and its overflow does not set flag 1.
- R11: Channel 1 in mode 3 holds both of its bytes.
- R12: An acknowledge pulse clears that channel's flag. An overflow in the same cycle as an acknowledge leaves the flag set.
- R13: A write to a count byte in the same cycle as a step stores the written value, and that step is dropped.
- R14: `baud_tick_o` pulses for one clock on each channel 1 overflow, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| cnt_pin_i | input | 2 | External count pins, one per channel |
| gate_pin_i | input | 2 | External gate pins, one per channel |
| irq_ack_i | input | 2 | Flag acknowledge, one per channel |
| ovf_flag_o | output | 2 | Overflow flags (interrupt requests) |
| baud_tick_o | output | 1 | One-clock pulse on each channel 1 overflow |

## Verification
Two pairs of events can fall in the same cycle. A register write can meet a hardware step. An overflow can meet an acknowledge. The bench lowers a count pin and times the register write, or the acknowledge, to the clock on which the synchronized edge arrives. It then judges the outcome from the count byte read back: the written value, not one higher. It also checks that the flag stays set after the wrapped count. Exact prescaler windows, which hold a fixed number of ticks, pin down timer-mode counts in split mode without depending on the prescaler's phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MD_13B    = 2'd0,
    MD_16B    = 2'd1,
    MD_RELOAD = 2'd2,
    MD_SPLIT  = 2'd3
  } tmr_mode_e;

  typedef struct packed {
    logic      gate;
    logic      ext_src;
    tmr_mode_e mode;
  } chan_cfg_t;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_MODE = 3'd1;
  localparam logic [2:0] ADDR_LO0  = 3'd2;
  localparam int         NUM_CH    = 2;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_gap
      p_tick_gap_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic meta_q, s0_q, s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      s0_q   <= 1'b0;
      s1_q   <= 1'b0;
    end else begin
      meta_q <= pin_i;
      s0_q   <= meta_q;
      s1_q   <= s0_q;
    end
  end

  assign fall_o = s1_q & ~s0_q;
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter bit SPLIT_OK = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tmr_mode_e mode_i,
  input  logic      step_i,
  input  logic      hi_step_i,
  input  logic      wr_lo_i,
  input  logic      wr_hi_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] lo_o,
  output logic [7:0] hi_o,
  output logic      ovf_o,
  output logic      hi_ovf_o
);
  logic [7:0] lo_q, hi_q, lo_n, hi_n;
  logic       split, lo_step;

  assign split   = SPLIT_OK && (mode_i == MD_SPLIT);
  // a write to the channel drops the step; split halves are independent
  assign lo_step = step_i & ~wr_lo_i & (split | ~wr_hi_i);

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    ovf_o    = 1'b0;
    hi_ovf_o = 1'b0;
    if (lo_step) begin
      unique case (mode_i)
        MD_13B: begin
          if (lo_q[4:0] == 5'h1f) begin
            lo_n[4:0] = 5'h00;
            hi_n      = hi_q + 8'd1;
            ovf_o     = (hi_q == 8'hff);
          end else begin
            lo_n[4:0] = lo_q[4:0] + 5'd1;
          end
        end
        MD_16B: begin
          {hi_n, lo_n} = {hi_q, lo_q} + 16'd1;
          ovf_o        = &{hi_q, lo_q};
        end
        MD_RELOAD: begin
          if (&lo_q) begin
            lo_n  = hi_q;
            ovf_o = 1'b1;
          end else begin
            lo_n = lo_q + 8'd1;
          end
        end
        default: begin
          if (split) begin
            lo_n  = lo_q + 8'd1;
            ovf_o = &lo_q;
          end
        end
      endcase
    end
    if (split && hi_step_i && !wr_hi_i) begin
      hi_n     = hi_q + 8'd1;
      hi_ovf_o = &hi_q;
    end
    if (wr_lo_i) lo_n = wdata_i;
    if (wr_hi_i) hi_n = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;

  p_wr_prio_r13 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> lo_q == $past(wdata_i));

  p_reload_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_RELOAD && step_i && lo_q == 8'hff && !wr_lo_i && !wr_hi_i)
      |=> (lo_q == $past(hi_q)) && (hi_q == $past(hi_q)));

  p_wrap16_r5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MD_16B && ovf_o) |=> (lo_q == 8'h00) && (hi_q == 8'h00));

  generate
    if (!SPLIT_OK) begin : g_freeze
      p_freeze_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == MD_SPLIT && !wr_lo_i && !wr_hi_i)
          |=> (lo_q == $past(lo_q)) && (hi_q == $past(hi_q)));
    end
  endgenerate
endmodule

// File: rtl/tmr_pair_top.sv
module tmr_pair_top
  import tmr_pkg::*;
#(
  parameter int PRESCALE = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic [1:0] cnt_pin_i,
  input  logic [1:0] gate_pin_i,
  input  logic [1:0] irq_ack_i,
  output logic [1:0] ovf_flag_o,
  output logic       baud_tick_o
);
  logic [7:0] ctrl_q, mode_q;
  logic       pre_tick, ctrl_wr, split0;
  chan_cfg_t  cfg   [NUM_CH];
  logic [NUM_CH-1:0] fall, src, run, step, ovf, hovf, set_tf, wr_lo, wr_hi;
  logic [7:0] lo [NUM_CH];
  logic [7:0] hi [NUM_CH];

  assign ctrl_wr = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign split0  = (cfg[0].mode == MD_SPLIT);

  tmr_prescale #(.DIV(PRESCALE)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(pre_tick)
  );

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam logic [2:0] A_LO = 3'(ADDR_LO0 + 2*ch);
      localparam logic [2:0] A_HI = 3'(ADDR_LO0 + 2*ch + 1);

      assign cfg[ch]   = chan_cfg_t'(mode_q[4*ch +: 4]);
      assign wr_lo[ch] = reg_we_i && (reg_addr_i == A_LO);
      assign wr_hi[ch] = reg_we_i && (reg_addr_i == A_HI);
      assign run[ch]   = ctrl_q[4+2*ch] & (~cfg[ch].gate | gate_pin_i[ch]);
      assign src[ch]   = cfg[ch].ext_src ? fall[ch] : pre_tick;

      tmr_fall_det u_fall (
        .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(cnt_pin_i[ch]), .fall_o(fall[ch])
      );

      tmr_chan #(.SPLIT_OK(ch == 0)) u_chan (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_i   (cfg[ch].mode),
        .step_i   (step[ch]),
        .hi_step_i(ch == 0 ? (ctrl_q[6] & pre_tick) : 1'b0),
        .wr_lo_i  (wr_lo[ch]),
        .wr_hi_i  (wr_hi[ch]),
        .wdata_i  (reg_wdata_i),
        .lo_o     (lo[ch]),
        .hi_o     (hi[ch]),
        .ovf_o    (ovf[ch]),
        .hi_ovf_o (hovf[ch])
      );
    end
  endgenerate

  // channel 1 loses its run bit to channel 0's high byte in split mode
  assign step[0]     = run[0] & src[0];
  assign step[1]     = split0 ? src[1] : (run[1] & src[1]);
  assign set_tf[0]   = ovf[0];
  assign set_tf[1]   = split0 ? hovf[0] : ovf[1];
  assign baud_tick_o = ovf[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == ADDR_MODE) mode_q <= reg_wdata_i;
      if (ctrl_wr) begin
        ctrl_q <= reg_wdata_i;
      end else begin
        for (int ch = 0; ch < NUM_CH; ch++) begin
          if (set_tf[ch])         ctrl_q[5+2*ch] <= 1'b1;
          else if (irq_ack_i[ch]) ctrl_q[5+2*ch] <= 1'b0;
        end
      end
    end
  end

  assign ovf_flag_o = {ctrl_q[7], ctrl_q[5]};

  always_comb begin
    unique case (reg_addr_i)
      3'd0:    reg_rdata_o = ctrl_q;
      3'd1:    reg_rdata_o = mode_q;
      3'd2:    reg_rdata_o = lo[0];
      3'd3:    reg_rdata_o = hi[0];
      3'd4:    reg_rdata_o = lo[1];
      3'd5:    reg_rdata_o = hi[1];
      default: reg_rdata_o = 8'h00;
    endcase
  end

  p_flag_set_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_tf[0] && !ctrl_wr) |=> ctrl_q[5]);

  p_ack_clear_r12 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i[0] && !set_tf[0] && !ctrl_wr) |=> !ctrl_q[5]);

  p_split_tf1_r10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (split0 && !hovf[0] && !ctrl_wr && !ctrl_q[7]) |=> !ctrl_q[7]);

  p_gate_hold_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg[0].gate && !gate_pin_i[0] && !wr_lo[0] && !wr_hi[0]) |=> lo[0] == $past(lo[0]));
endmodule

// File: tb/sim_tmr_pair_top.sv
module sim_tmr_pair_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] gate_pin = 2'b00;
  logic [1:0] ack = 2'b00;
  logic [1:0] flags;
  logic       baud;
  int checks = 0, errors = 0, baud_cnt = 0;

  always #10 clk = ~clk;

  tmr_pair_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .cnt_pin_i(cnt_pin),
    .gate_pin_i(gate_pin), .irq_ack_i(ack), .ovf_flag_o(flags), .baud_tick_o(baud)
  );

  always @(posedge clk) if (rst_n && baud) baud_cnt++;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int ch);
    cnt_pin[ch] = 1'b0;
    repeat (3) @(negedge clk);
    cnt_pin[ch] = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic setup(input logic [7:0] md, input logic [7:0] l0, input logic [7:0] h0);
    wr(3'd0, 8'h00); wr(3'd1, md); wr(3'd2, l0); wr(3'd3, h0);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d); chk("R1 reset reg", d, 0);
    end
    chk("R1 reset flags", flags, 0);
  endtask

  task automatic t_regmap;
    logic [7:0] d;
    wr(3'd1, 8'hA5); rd(3'd1, d); chk("R2 mode readback", d, 8'hA5);
    wr(3'd0, 8'hA3); rd(3'd0, d); chk("R2 ctrl readback", d, 8'hA3);
    chk("R2 flag outputs", flags, 2'b11);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_mode1;
    logic [7:0] d;
    setup(8'h05, 8'hFE, 8'hFF); wr(3'd0, 8'h10);
    pulse(0); rd(3'd2, d); chk("R3 edge count", d, 8'hFF);
    chk("R5 no flag yet", flags, 0);
    pulse(0); rd(3'd2, d); chk("R5 wrap lo", d, 0);
    rd(3'd3, d); chk("R5 wrap hi", d, 0);
    chk("R5 flag set", flags, 2'b01);
    ack = 2'b01; @(negedge clk); ack = 2'b00;
    chk("R12 ack clears", flags, 0);
  endtask

  task automatic t_mode0;
    logic [7:0] d;
    setup(8'h04, 8'hFF, 8'h12); wr(3'd0, 8'h10);
    pulse(0); rd(3'd2, d); chk("R6 lo keeps upper bits", d, 8'hE0);
    rd(3'd3, d); chk("R6 carry to hi", d, 8'h13);
    chk("R6 no flag", flags, 0);
    wr(3'd2, 8'h7F); wr(3'd3, 8'hFF);
    pulse(0); rd(3'd2, d); chk("R6 wrap lo", d, 8'h60);
    rd(3'd3, d); chk("R6 wrap hi", d, 0);
    chk("R6 flag", flags, 2'b01);
  endtask

  task automatic t_mode2;
    logic [7:0] d;
    setup(8'h06, 8'hFF, 8'h80); wr(3'd0, 8'h10);
    pulse(0); rd(3'd2, d); chk("R7 reload", d, 8'h80);
    rd(3'd3, d); chk("R7 hi unchanged", d, 8'h80);
    chk("R7 flag", flags, 2'b01);
    pulse(0); rd(3'd2, d); chk("R7 count after reload", d, 8'h81);
  endtask

  task automatic t_gate;
    logic [7:0] d;
    setup(8'h0D, 8'h00, 8'h00); wr(3'd0, 8'h10);
    gate_pin = 2'b00;
    pulse(0); rd(3'd2, d); chk("R4 gated off", d, 0);
    gate_pin = 2'b01;
    pulse(0); rd(3'd2, d); chk("R4 gated on", d, 1);
    gate_pin = 2'b00;
  endtask

  task automatic t_timer;
    logic [7:0] d;
    setup(8'h01, 8'h00, 8'h00);
    wr(3'd0, 8'h10);
    repeat (59) @(negedge clk);
    wr(3'd0, 8'h00);
    rd(3'd2, d); chk("R3 prescale 60 clocks", d, 10);
  endtask

  task automatic t_split;
    logic [7:0] d;
    int b0;
    setup(8'h57, 8'hFF, 8'hFF);
    wr(3'd0, 8'h50);
    repeat (12) @(negedge clk);
    rd(3'd3, d); chk("R9 split hi ticks", d, 8'h01);
    chk("R9 flag1 from hi", flags, 2'b10);
    rd(3'd2, d); chk("R8 lo idle", d, 8'hFF);
    pulse(0); rd(3'd2, d); chk("R8 lo wrap", d, 0);
    chk("R8 flag0", flags[0], 1);
    wr(3'd0, 8'h00);
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    b0 = baud_cnt;
    pulse(1); rd(3'd4, d); chk("R10 ch1 runs without run bit", d, 0);
    chk("R10 flag1 untouched", flags[1], 0);
    chk("R14 baud pulse", baud_cnt - b0, 1);
  endtask

  task automatic t_freeze;
    logic [7:0] d;
    setup(8'h75, 8'h00, 8'h00);
    wr(3'd4, 8'h33); wr(3'd0, 8'h40);
    pulse(1); rd(3'd4, d); chk("R11 ch1 frozen", d, 8'h33);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_wr_prio;
    logic [7:0] d;
    setup(8'h05, 8'h10, 8'h00); wr(3'd0, 8'h10);
    cnt_pin[0] = 1'b0;
    repeat (2) @(negedge clk);
    wr(3'd2, 8'h40);
    cnt_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    rd(3'd2, d); chk("R13 write beats step", d, 8'h40);
    rd(3'd3, d); chk("R13 hi untouched", d, 0);
  endtask

  task automatic t_ack_race;
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    cnt_pin[0] = 1'b0;
    repeat (2) @(negedge clk);
    ack = 2'b01; @(negedge clk); ack = 2'b00;
    cnt_pin[0] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R12 overflow beats ack", flags[0], 1);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regmap;
    t_mode1;
    t_mode0;
    t_mode2;
    t_gate;
    t_timer;
    t_split;
    t_freeze;
    t_wr_prio;
    t_ack_race;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule